// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter with eight multiplexed inputs. Software reaches it over a simple byte-wide processor bus. A control byte chooses the input channel, enables the completion interrupt, starts a conversion and reports when the conversion has finished. The block drives the 3-bit select of an external analog multiplexer and a 10-bit trial code to an external DAC. On each step it reads back a single comparator bit.

A conversion seeds its trial code at mid-scale and then settles one bit per step, from the most significant bit down to the least significant. After the last step the code is copied into a readable high/low result pair, the end-of-conversion flag rises and, if enabled, a one-cycle interrupt pulse is issued. Each new result replaces the previous one, whether or not software has read it. With the default comparator path the block takes one clock per bit. A parameter adds a synchronizer in front of the comparator and stretches each step to match.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, every bus address reads 0x00, `irq` is 0, `mux_sel` is 0 and `dac_code` is 0.
- R2: The control byte lives at address 0xFA. Bits 7..5 hold the channel and bit 4 holds the interrupt enable. Both read back as written, and bits 2 and 1 always read 0. The channel field drives `mux_sel` directly.
- R3: Bit 3 of the control byte is the end-of-conversion flag, and it is read-only. A write of 1 to it without a start leaves it at 0.
- R4: Writing 1 to bit 0 of the control byte requests a conversion. Bit 0 reads 1 only until the conversion begins one cycle later, and then reads 0.
- R5: The end-of-conversion flag goes to 0 on the write that carries a start bit. It stays at 0 for every comparison step.
- R6: In the first conversion cycle `dac_code` is 10'h200.
- R7: `cmp_in` = 1 means the analog level is at or above `dac_code`, and the trial bit is then kept. Otherwise the trial bit is cleared. The final code is the largest code not above the input. With default parameters the flag reads 1 exactly 11 clock edges after the start-write edge.
- R8: Address 0xFB returns result bits 9..2. Address 0xFC returns result bits 1..0 in bits 1..0, and 0 in its upper six bits. `dac_code` holds the final code while idle.
- R9: When the interrupt enable is 1, `irq` is high for exactly one cycle, and that cycle is the first one in which the flag reads 1. When the enable is 0, no pulse occurs.
- R10: A later conversion overwrites the result pair even if the previous result was never read.
- R11: Addresses other than 0xFA, 0xFB and 0xFC read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Bus byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| cmp_in | input | 1 | Comparator: 1 when analog level >= `dac_code` |
| dac_code | output | 10 | Trial code to the external DAC |
| mux_sel | output | 3 | Analog input channel select |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
A wrong bit index or keep/clear decision inside the search shows up in `dac_code` from the very next step. It ends in a result that differs from the modelled input once the flag rises, 11 cycles after the start. A stuck step counter or state register changes the start-to-flag latency, or stops the flag from ever rising, and the bench's bounded wait catches both. Errors in the flag or the interrupt path appear in the cycle the conversion ends, because the bench samples the flag, the pulse and its absence one cycle later on every conversion.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
   typedef enum logic [0:0] {ENG_IDLE = 1'b0, ENG_CONV = 1'b1} eng_state_e;

   localparam int CTRL_CH_LSB    = 5;
   localparam int CTRL_IE_BIT    = 4;
   localparam int CTRL_EOC_BIT   = 3;
   localparam int CTRL_START_BIT = 0;
   localparam int BYTE_W         = 8;
endpackage

// File: rtl/sar_ctrl_reg.sv
`timescale 1ns/1ps
module sar_ctrl_reg
   import sar_pkg::*;
#(
   parameter int              ADDR_W    = 8,
   parameter int              CH_W      = 3,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hFA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic              start_ack,
   input  logic              conv_done,
   output logic [CH_W-1:0]   ch_sel,
   output logic              int_en,
   output logic              eoc,
   output logic              start_req,
   output logic [BYTE_W-1:0] ctrl_rdata
);
   if (CH_W < 1 || CH_W > BYTE_W - CTRL_CH_LSB) begin : g_bad_ch_w
      $error("sar_ctrl_reg: CH_W out of range");
   end

   logic addr_hit;
   logic wr_ctrl;
   logic wr_start;

   assign addr_hit = (bus_addr == CTRL_ADDR);
   assign wr_ctrl  = bus_we && addr_hit;
   assign wr_start = wr_ctrl && bus_wdata[CTRL_START_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_sel <= '0;
         int_en <= 1'b0;
      end else if (wr_ctrl) begin
         ch_sel <= bus_wdata[CTRL_CH_LSB +: CH_W];
         int_en <= bus_wdata[CTRL_IE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_req <= 1'b0;
      end else if (wr_start) begin
         start_req <= 1'b1;
      end else if (start_ack) begin
         start_req <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc <= 1'b0;
      end else if (wr_start || start_ack) begin
         eoc <= 1'b0;
      end else if (conv_done) begin
         eoc <= 1'b1;
      end
   end

   always_comb begin
      ctrl_rdata = '0;
      if (addr_hit) begin
         ctrl_rdata[CTRL_CH_LSB +: CH_W] = ch_sel;
         ctrl_rdata[CTRL_IE_BIT]         = int_en;
         ctrl_rdata[CTRL_EOC_BIT]        = eoc;
         ctrl_rdata[CTRL_START_BIT]      = start_req;
      end
   end
endmodule

// File: rtl/sar_engine.sv
`timescale 1ns/1ps
module sar_engine
   import sar_pkg::*;
#(
   parameter int RES_W  = 10,
   parameter int SETTLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             cmp_bit,
   output logic             start_ack,
   output logic             busy,
   output logic             done,
   output logic [RES_W-1:0] trial,
   output logic [RES_W-1:0] result
);
   localparam int IDX_W = $clog2(RES_W);
   localparam int SET_W = (SETTLE > 0) ? $clog2(SETTLE + 1) : 1;
   localparam logic [RES_W-1:0] SEED    = RES_W'(1) << (RES_W - 1);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

   if (RES_W < 2) begin : g_bad_res_w
      $error("sar_engine: RES_W must be at least 2");
   end
   if (SETTLE < 0) begin : g_bad_settle
      $error("sar_engine: SETTLE must not be negative");
   end

   eng_state_e       state;
   logic [IDX_W-1:0] idx;
   logic [RES_W-1:0] sar;
   logic [RES_W-1:0] next_code;
   logic             settled;
   logic             step_fire;
   logic             reload;

   assign busy      = (state == ENG_CONV);
   assign start_ack = (state == ENG_IDLE) && start_req;
   assign step_fire = busy && settled;
   assign done      = step_fire && (idx == '0);
   assign reload    = start_ack || (step_fire && (idx != '0));
   assign trial     = sar;
   assign result    = next_code;

   if (SETTLE == 0) begin : g_no_settle
      assign settled = 1'b1;
   end else begin : g_settle
      logic [SET_W-1:0] wait_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wait_cnt <= '0;
         end else if (reload) begin
            wait_cnt <= SET_W'(SETTLE);
         end else if (busy && wait_cnt != '0) begin
            wait_cnt <= wait_cnt - 1'b1;
         end
      end
      assign settled = (wait_cnt == '0);
   end

   always_comb begin
      next_code = sar;
      if (!cmp_bit) begin
         next_code[idx] = 1'b0;
      end
      if (idx != '0) begin
         next_code[idx - 1'b1] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ENG_IDLE;
         idx   <= '0;
         sar   <= '0;
      end else begin
         case (state)
            ENG_IDLE: begin
               if (start_ack) begin
                  state <= ENG_CONV;
                  idx   <= TOP_IDX;
                  sar   <= SEED;
               end
            end
            ENG_CONV: begin
               if (step_fire) begin
                  sar <= next_code;
                  if (idx == '0) begin
                     state <= ENG_IDLE;
                  end else begin
                     idx <= idx - 1'b1;
                  end
               end
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sar_result_reg.sv
`timescale 1ns/1ps
module sar_result_reg
   import sar_pkg::*;
#(
   parameter int              RES_W   = 10,
   parameter int              ADDR_W  = 8,
   parameter logic [ADDR_W-1:0] HI_ADDR = 8'hFB,
   parameter logic [ADDR_W-1:0] LO_ADDR = 8'hFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [RES_W-1:0]  code_in,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [BYTE_W-1:0] data_rdata
);
   localparam int LO_W = RES_W - BYTE_W;

   if (RES_W <= BYTE_W || RES_W > 2 * BYTE_W) begin : g_bad_res_w
      $error("sar_result_reg: RES_W must lie in 9..16");
   end

   logic [RES_W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= '0;
      end else if (capture) begin
         held <= code_in;
      end
   end

   always_comb begin
      data_rdata = '0;
      if (bus_addr == HI_ADDR) begin
         data_rdata = held[RES_W-1 -: BYTE_W];
      end else if (bus_addr == LO_ADDR) begin
         data_rdata[LO_W-1:0] = held[LO_W-1:0];
      end
   end
endmodule

// File: rtl/sar_adc_ctrl.sv
`timescale 1ns/1ps
module sar_adc_ctrl
   import sar_pkg::*;
#(
   parameter int              RES_W     = 10,
   parameter int              CH_W      = 3,
   parameter int              ADDR_W    = 8,
   parameter int              CMP_SYNC  = 0,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hFA,
   parameter logic [ADDR_W-1:0] HI_ADDR   = 8'hFB,
   parameter logic [ADDR_W-1:0] LO_ADDR   = 8'hFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              cmp_in,
   output logic [RES_W-1:0]  dac_code,
   output logic [CH_W-1:0]   mux_sel,
   output logic              irq
);
   if (CMP_SYNC < 0 || CMP_SYNC > 4) begin : g_bad_sync
      $error("sar_adc_ctrl: CMP_SYNC must lie in 0..4");
   end
   if (CTRL_ADDR == HI_ADDR || CTRL_ADDR == LO_ADDR || HI_ADDR == LO_ADDR) begin : g_bad_map
      $error("sar_adc_ctrl: register addresses must differ");
   end

   logic             cmp_bit;
   logic             eng_ack;
   logic             eng_busy;
   logic             eng_done;
   logic [RES_W-1:0] eng_result;
   logic             start_req;
   logic             int_en;
   logic             eoc_flag;
   logic [7:0]       ctrl_rd;
   logic [7:0]       data_rd;

   if (CMP_SYNC == 0) begin : g_cmp_direct
      assign cmp_bit = cmp_in;
   end else begin : g_cmp_sync
      logic [CMP_SYNC-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q <= '0;
         end else begin
            sync_q <= {sync_q[CMP_SYNC-1:0] << 1} | CMP_SYNC'(cmp_in);
         end
      end
      assign cmp_bit = sync_q[CMP_SYNC-1];
   end

   sar_ctrl_reg #(
      .ADDR_W   (ADDR_W),
      .CH_W     (CH_W),
      .CTRL_ADDR(CTRL_ADDR)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .start_ack (eng_ack),
      .conv_done (eng_done),
      .ch_sel    (mux_sel),
      .int_en    (int_en),
      .eoc       (eoc_flag),
      .start_req (start_req),
      .ctrl_rdata(ctrl_rd)
   );

   sar_engine #(
      .RES_W (RES_W),
      .SETTLE(CMP_SYNC)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_req(start_req),
      .cmp_bit  (cmp_bit),
      .start_ack(eng_ack),
      .busy     (eng_busy),
      .done     (eng_done),
      .trial    (dac_code),
      .result   (eng_result)
   );

   sar_result_reg #(
      .RES_W  (RES_W),
      .ADDR_W (ADDR_W),
      .HI_ADDR(HI_ADDR),
      .LO_ADDR(LO_ADDR)
   ) u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (eng_done),
      .code_in   (eng_result),
      .bus_addr  (bus_addr),
      .data_rdata(data_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else begin
         irq <= eng_done && int_en;
      end
   end

   assign bus_rdata = ctrl_rd | data_rd;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
`timescale 1ns/1ps
module sar_adc_ctrl_chk #(
   parameter int RES_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq,
   input logic             eoc,
   input logic             busy,
   input logic             start_ack,
   input logic [RES_W-1:0] dac_code
);
   localparam logic [RES_W-1:0] MID = RES_W'(1) << (RES_W - 1);

   a_r6_seed_midscale: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> dac_code == MID);

   a_r4_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
      start_ack |=> busy);

   a_r5_eoc_low_in_steps: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !eoc);

   a_r9_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   a_r9_irq_with_eoc_rise: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $rose(eoc));

   a_r8_idle_code_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> $stable(dac_code));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_W(RES_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq      (irq),
   .eoc      (eoc_flag),
   .busy     (eng_busy),
   .start_ack(eng_ack),
   .dac_code (dac_code)
);

// File: tb/tb_sar_adc_ctrl.sv
`timescale 1ns/1ps
module tb_sar_adc_ctrl;
   localparam logic [7:0] A_CTRL = 8'hFA;
   localparam logic [7:0] A_HI   = 8'hFB;
   localparam logic [7:0] A_LO   = 8'hFC;
   localparam int         NVEC   = 8;
   // {channel[2:0], int_en, analog level[9:0]}
   localparam logic [13:0] VEC [NVEC] = '{
      {3'd0, 1'b1, 10'h000}, {3'd1, 1'b0, 10'h3FF},
      {3'd2, 1'b1, 10'h200}, {3'd3, 1'b1, 10'h1FF},
      {3'd4, 1'b0, 10'h155}, {3'd5, 1'b1, 10'h2AA},
      {3'd6, 1'b1, 10'h001}, {3'd7, 1'b0, 10'h3FE}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       cmp_in;
   logic [9:0] dac_code;
   logic [2:0] mux_sel;
   logic       irq;
   logic [9:0] ain [8];
   int         checks = 0;
   int         errors = 0;
   bit         done_flag = 1'b0;

   always #4 clk = ~clk;

   assign cmp_in = (ain[mux_sel] >= dac_code);

   sar_adc_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
      .dac_code(dac_code), .mux_sel(mux_sel), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // Starts a conversion and checks timing, flags and interrupt.
   task automatic convert(input logic [2:0] ch, input logic ie, input logic [9:0] lvl);
      logic [7:0] rd;
      int n;
      ain[ch] = lvl;
      bus_write(A_CTRL, {ch, ie, 4'b0001});
      n = 0;
      rd = 8'h00;
      while (rd[3] == 1'b0 && n < 100) begin
         @(negedge clk);
         n++;
         bus_read(A_CTRL, rd);
         if (n == 1) begin
            chk("R4 start bit self-clears", {31'd0, rd[0]}, 32'd0);
            chk("R6 mid-scale seed", {22'd0, dac_code}, 32'h200);
         end
         if (rd[3] == 1'b0 && n < 11) begin
            if (irq) chk("R9 irq before end", 32'd1, 32'd0);
         end
      end
      chk("R7 start-to-flag latency", n, 32'd11);
      chk("R9 irq with flag rise", {31'd0, irq}, {31'd0, ie});
      chk("R2 mux_sel follows channel", {29'd0, mux_sel}, {29'd0, ch});
      @(negedge clk);
      chk("R9 irq lasts one cycle", {31'd0, irq}, 32'd0);
      chk("R8 dac_code holds result", {22'd0, dac_code}, {22'd0, lvl});
   endtask

   initial begin
      #1_200_000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
   end

   initial begin
      logic [7:0] rd;
      for (int i = 0; i < 8; i++) ain[i] = 10'h000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      bus_read(A_CTRL, rd); chk("R1 ctrl reset", rd, 8'h00);
      bus_read(A_HI, rd);   chk("R1 hi reset", rd, 8'h00);
      bus_read(A_LO, rd);   chk("R1 lo reset", rd, 8'h00);
      chk("R1 irq reset", {31'd0, irq}, 32'd0);
      chk("R1 dac reset", {22'd0, dac_code}, 32'd0);
      chk("R1 mux reset", {29'd0, mux_sel}, 32'd0);

      // R3: eoc bit is read-only; R2: field readback and zero bits
      bus_write(A_CTRL, 8'b1011_1110);
      bus_read(A_CTRL, rd);
      chk("R3 eoc not writable", {31'd0, rd[3]}, 32'd0);
      chk("R2 ctrl readback", rd, 8'b1011_0000);
      chk("R2 mux_sel from write", {29'd0, mux_sel}, 32'd5);

      // R11: unmapped address
      bus_read(8'h00, rd); chk("R11 unmapped reads zero", rd, 8'h00);
      bus_read(8'hFD, rd); chk("R11 unmapped FD reads zero", rd, 8'h00);

      // Vector walk: R7, R8, R9 across channels and levels
      for (int v = 0; v < NVEC; v++) begin
         logic [9:0] lvl;
         lvl = VEC[v][9:0];
         convert(VEC[v][13:11], VEC[v][10], lvl);
         bus_read(A_HI, rd); chk("R8 high byte", rd, lvl[9:2]);
         bus_read(A_LO, rd); chk("R8 low byte", rd, {6'd0, lvl[1:0]});
         bus_read(A_CTRL, rd);
         chk("R2 ctrl after conversion", rd, {VEC[v][13:10], 4'b1000});
      end

      // R5: a start write clears a set flag at once
      ain[2] = 10'h0F0;
      bus_write(A_CTRL, {3'd2, 1'b0, 4'b0001});
      bus_read(A_CTRL, rd);
      chk("R5 eoc cleared by start", {31'd0, rd[3]}, 32'd0);
      repeat (12) @(negedge clk);
      bus_read(A_CTRL, rd);
      chk("R5 eoc set after steps", {31'd0, rd[3]}, 32'd1);

      // R10: two conversions, no read in between
      convert(3'd1, 1'b0, 10'h0C3);
      convert(3'd6, 1'b1, 10'h31C);
      bus_read(A_HI, rd); chk("R10 overwrite high", rd, 8'hC7);
      bus_read(A_LO, rd); chk("R10 overwrite low", rd, 8'h00);

      // R7: in-between level resolves to floor of the input
      ain[4] = 10'h2D7;
      convert(3'd4, 1'b1, 10'h2D7);
      bus_read(A_HI, rd); chk("R7 result high", rd, 8'hB5);
      bus_read(A_LO, rd); chk("R7 result low", rd, 8'h03);

      report();
   end
endmodule